// File: doc/BRIEF.md
# SPI Memory-Companion Command Decoder

This block is the serial slave front end of a small memory and companion-register device. After chip select goes low it shifts in an 8-bit op-code, MSB first, on rising SCK edges. It then handles the transaction in one of three ways. Single-function commands need nothing more. Status commands move exactly one data byte. Memory and companion commands take an address byte followed by a burst of data bytes. A 256-byte memory array and a 16-entry companion register file are modelled inside the block.

Every write passes through a write-enable latch. The latch is clear after reset. Only the write-enable command can set it. The rising chip-select edge that ends any write-class transaction clears it again. The serial output is driven only while read data is being returned. At all other times the output enable is low, which stands for high impedance.

Top module: `spi_companion_dec`

## Requirements
- R1: The op-code and all following bytes are sampled MSB first on rising SCK edges while `cs_n` is low. Read data is presented MSB first, with each bit changing after a falling SCK edge.
- R2: After reset the write latch is clear, `miso_en` is low, and a status read returns 0x00.
- R3: Op-code 0x06 sets the write latch. The latch is visible as bit 1 of the status byte.
- R4: The rising `cs_n` edge that ends a transaction with op-code 0x04, 0x01, 0x02 or 0x12 clears the latch. Op-codes 0x03, 0x05, 0x13 and 0x06 never clear it.
- R5: Op-code 0x01 followed by one data byte loads status bits 7, 3 and 2 from that byte when the latch is set. Bit 1 ignores the data byte. Bits 6, 5, 4 and 0 always read 0.
- R6: When the latch is clear, op-codes 0x01, 0x02 and 0x12 change no stored state.
- R7: Op-code 0x03 (read) and 0x02 (write) take an address byte and then a burst of bytes on the 256-byte memory. The address increments after each byte and wraps from 0xFF to 0x00.
- R8: Op-code 0x13 (read) and 0x12 (write) take an address byte and then a burst on the 16-register companion file. The low 4 address bits select the register, and the address wraps from 15 to 0.
- R9: `miso_en` is high only during the data bytes of 0x05, 0x03 and 0x13. Op-code 0x05 drives exactly one byte. `miso_en` stays low during every other op-code and whenever `cs_n` is high.
- R10: An op-code outside the eight listed is ignored until `cs_n` rises. It leaves the latch unchanged and never drives the output.
- R11: A transaction ended by `cs_n` before 8 op-code bits have arrived has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; oversamples the serial pins |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the bus master |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial read data (valid when `miso_en` is high) |
| miso_en | output | 1 | Output enable; low means high impedance |

## Verification
The main function is exercised with a seeded random mix of all eight op-codes plus unknown codes, with random addresses and burst lengths. The expected results come from a reference model, so any mismatch in latch gating or write ordering shows up in the data read back later. Directed sequences cover the cases that random traffic rarely reaches. Bursts that cross the end of each address space separate wrapping from overrunning. A status write whose data has bit 1 set shows whether the data byte can set the latch. A 7-bit op-code separates discarding a partial command from executing it. Reads placed between write-enable and a write show that only write-class commands clear the latch.

// File: rtl/spi_companion_dec.sv
module spi_companion_dec #(
  parameter int          MEM_AW     = 8,
  parameter int          CREG_AW    = 4,
  parameter int          LATCH_BIT  = 1,
  parameter logic [7:0]  STAT_WMASK = 8'h8C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic miso_en
);

  localparam int MEM_DEPTH  = 1 << MEM_AW;
  localparam int CREG_DEPTH = 1 << CREG_AW;
  localparam logic [7:0] KEEP_MASK = STAT_WMASK & ~(8'd1 << LATCH_BIT);

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;
  localparam logic [7:0] OP_RDPC = 8'h13;
  localparam logic [7:0] OP_WRPC = 8'h12;

  typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DATA, PH_IDLE} phase_t;

  logic       sck_d, cs_d;
  logic [2:0] bitcnt;
  logic [6:0] shin;
  phase_t     ph;
  logic [7:0] op;
  logic       opv;
  logic [7:0] addr;
  logic [7:0] txb;
  logic       wel;
  logic [7:0] stat;
  logic       drv, dout;
  logic [7:0] mem  [MEM_DEPTH];
  logic [7:0] creg [CREG_DEPTH];

  wire       sck_rise  = sck & ~sck_d & ~cs_n;
  wire       sck_fall  = ~sck & sck_d & ~cs_n;
  wire       cs_rise   = cs_n & ~cs_d;
  wire [7:0] rx_byte   = {shin, mosi};
  wire       byte_done = sck_rise && (bitcnt == 3'd7);
  wire [7:0] addr_nx   = addr + 8'd1;

  wire is_rd    = (op == OP_RDSR) || (op == OP_READ) || (op == OP_RDPC);
  wire wr_class = (op == OP_WRDI) || (op == OP_WRSR) || (op == OP_WRIT) || (op == OP_WRPC);
  wire [7:0] status_rd = (stat & KEEP_MASK) | ({7'd0, wel} << LATCH_BIT);

  wire in_data = byte_done && (ph == PH_DATA);
  wire mem_we  = in_data && wel && (op == OP_WRIT);
  wire creg_we = in_data && wel && (op == OP_WRPC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= 8'd0;
      for (int i = 0; i < CREG_DEPTH; i++) creg[i] <= 8'd0;
    end else begin
      if (mem_we)  mem[addr[MEM_AW-1:0]]   <= rx_byte;
      if (creg_we) creg[addr[CREG_AW-1:0]] <= rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
      bitcnt <= '0;
      shin   <= '0;
      ph     <= PH_OP;
      op     <= '0;
      opv    <= 1'b0;
      addr   <= '0;
      txb    <= '0;
      wel    <= 1'b0;
      stat   <= '0;
      drv    <= 1'b0;
      dout   <= 1'b0;
    end else begin
      sck_d <= sck;
      cs_d  <= cs_n;
      if (cs_n) begin
        bitcnt <= '0;
        ph     <= PH_OP;
        opv    <= 1'b0;
        drv    <= 1'b0;
        if (cs_rise && opv && wr_class) wel <= 1'b0;
      end else begin
        if (sck_fall) begin
          drv  <= (ph == PH_DATA) && is_rd;
          dout <= txb[~bitcnt];
        end
        if (sck_rise) begin
          bitcnt <= bitcnt + 3'd1;
          shin   <= {shin[5:0], mosi};
        end
        if (byte_done) begin
          case (ph)
            PH_OP: begin
              op <= rx_byte;
              case (rx_byte)
                OP_WREN: begin wel <= 1'b1; opv <= 1'b1; ph <= PH_IDLE; end
                OP_WRDI: begin opv <= 1'b1; ph <= PH_IDLE; end
                OP_RDSR: begin opv <= 1'b1; txb <= status_rd; ph <= PH_DATA; end
                OP_WRSR: begin opv <= 1'b1; ph <= PH_DATA; end
                OP_READ, OP_WRIT, OP_RDPC, OP_WRPC: begin
                  opv <= 1'b1;
                  ph  <= PH_ADDR;
                end
                default: begin opv <= 1'b0; ph <= PH_IDLE; end
              endcase
            end
            PH_ADDR: begin
              addr <= rx_byte;
              ph   <= PH_DATA;
              txb  <= (op == OP_RDPC) ? creg[rx_byte[CREG_AW-1:0]]
                                      : mem[rx_byte[MEM_AW-1:0]];
            end
            PH_DATA: begin
              case (op)
                OP_RDSR: ph <= PH_IDLE;
                OP_WRSR: begin
                  if (wel) stat <= rx_byte & KEEP_MASK;
                  ph <= PH_IDLE;
                end
                OP_READ: begin
                  addr <= addr_nx;
                  txb  <= mem[addr_nx[MEM_AW-1:0]];
                end
                OP_RDPC: begin
                  addr <= addr_nx;
                  txb  <= creg[addr_nx[CREG_AW-1:0]];
                end
                default: addr <= addr_nx;
              endcase
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign miso_en = drv;
  assign miso    = drv & dout;

endmodule

module spi_companion_dec_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic miso_en,
  input logic wel
);

  p_latch_set_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !cs_n);

  p_latch_clear_at_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> cs_n);

  p_hiz_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !miso_en);

  p_drive_only_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_en) |-> !cs_n);

endmodule

bind spi_companion_dec spi_companion_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso_en(miso_en), .wel(wel)
);

// File: tb/spi_companion_dec_tb.sv
`timescale 1ns/1ps
module spi_companion_dec_tb;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  wire  miso, miso_en;

  always #2 clk = ~clk;

  spi_companion_dec u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_en(miso_en)
  );

  localparam logic [7:0] MASK = 8'h8C;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] txq [0:15];
  logic [7:0] rxq [0:15];
  bit en_seen;
  logic [7:0] mem_m [0:255];
  logic [7:0] cr_m [0:15];
  logic [7:0] st_m = 8'h00;
  bit wel_m = 1'b0;

  function automatic logic [7:0] status_exp();
    return (st_m & MASK) | {6'd0, wel_m, 1'b0};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(int nbits);
    @(negedge clk);
    cs_n = 1'b0;
    en_seen = 1'b0;
    wait_clk(4);
    for (int b = 0; b < nbits; b++) begin
      mosi = txq[b/8][7 - (b % 8)];
      wait_clk(4);
      rxq[b/8][7 - (b % 8)] = miso;
      if (miso_en) en_seen = 1'b1;
      sck = 1'b1;
      wait_clk(4);
      if (miso_en) en_seen = 1'b1;
      sck = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(6);
  endtask

  function automatic bit known_op(logic [7:0] op);
    return op inside {8'h06, 8'h04, 8'h05, 8'h01, 8'h03, 8'h02, 8'h13, 8'h12};
  endfunction

  task automatic do_txn(logic [7:0] op, logic [7:0] a, int nd_in, string req);
    int hdr, nd;
    bit rd;
    rd  = op inside {8'h05, 8'h03, 8'h13};
    hdr = (op inside {8'h03, 8'h02, 8'h13, 8'h12}) ? 2 : 1;
    nd  = (op inside {8'h05, 8'h01}) ? 1 :
          (op inside {8'h06, 8'h04}) ? 0 : nd_in;
    txq[0] = op;
    txq[1] = a;
    for (int i = 0; i < nd; i++) txq[hdr+i] = rd ? 8'h00 : 8'($urandom);
    if (!known_op(op)) for (int i = 1; i < 1 + nd; i++) txq[i] = 8'($urandom);
    xfer((hdr + nd) * 8);
    if (rd) begin
      check("R9", {7'd0, en_seen}, 8'd1, "read drives output");
      for (int i = 0; i < nd; i++) begin
        logic [7:0] ai;
        logic [7:0] exp;
        ai  = a + 8'(i);
        exp = (op == 8'h03) ? mem_m[ai] : (op == 8'h13) ? cr_m[ai[3:0]] : status_exp();
        check(req, rxq[hdr+i], exp, "read byte");
      end
    end else begin
      check("R9", {7'd0, en_seen}, 8'd0, "output stays high-Z");
    end
    case (op)
      8'h06: wel_m = 1'b1;
      8'h04: wel_m = 1'b0;
      8'h01: begin if (wel_m) st_m = txq[1] & MASK; wel_m = 1'b0; end
      8'h02: begin
        if (wel_m) for (int i = 0; i < nd; i++) mem_m[8'(a + 8'(i))] = txq[2+i];
        wel_m = 1'b0;
      end
      8'h12: begin
        if (wel_m) for (int i = 0; i < nd; i++) cr_m[4'(a + 8'(i))] = txq[2+i];
        wel_m = 1'b0;
      end
      default: ;
    endcase
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
    for (int i = 0; i < 16; i++) cr_m[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    check("R2", {7'd0, miso_en}, 8'd0, "enable after reset");
    do_txn(8'h05, 8'h00, 1, "R2");

    do_txn(8'h02, 8'h05, 2, "R6");
    do_txn(8'h03, 8'h05, 2, "R6");
    do_txn(8'h12, 8'h03, 1, "R6");
    do_txn(8'h13, 8'h03, 1, "R6");

    do_txn(8'h06, 8'h00, 0, "R3");
    do_txn(8'h05, 8'h00, 1, "R3");

    txq[0] = 8'h04;
    xfer(7);
    do_txn(8'h05, 8'h00, 1, "R11");
    do_txn(8'h04, 8'h00, 0, "R4");
    txq[0] = 8'h06;
    xfer(7);
    do_txn(8'h05, 8'h00, 1, "R11");

    do_txn(8'h06, 8'h00, 0, "R10");
    do_txn(8'hA5, 8'h00, 2, "R10");
    do_txn(8'h05, 8'h00, 1, "R10");

    do_txn(8'h03, 8'h10, 1, "R4");
    do_txn(8'h13, 8'h01, 1, "R4");
    do_txn(8'h05, 8'h00, 1, "R4");

    txq[1] = 8'hFF;
    txq[0] = 8'h01;
    xfer(16);
    st_m = 8'hFF & MASK;
    wel_m = 1'b0;
    do_txn(8'h05, 8'h00, 1, "R5");
    do_txn(8'h06, 8'h00, 0, "R5");
    txq[1] = 8'h02;
    txq[0] = 8'h01;
    xfer(16);
    st_m = 8'h00;
    wel_m = 1'b0;
    do_txn(8'h05, 8'h00, 1, "R5");

    do_txn(8'h06, 8'h00, 0, "R7");
    do_txn(8'h02, 8'hFE, 4, "R7");
    do_txn(8'h03, 8'hFE, 4, "R1/R7");

    do_txn(8'h06, 8'h00, 0, "R8");
    do_txn(8'h12, 8'h0E, 4, "R8");
    do_txn(8'h13, 8'h0E, 4, "R8");
    do_txn(8'h13, 8'hFE, 4, "R8");

    for (int n = 0; n < 90; n++) begin
      logic [7:0] op;
      case ($urandom_range(0, 10))
        0, 1:    op = 8'h06;
        2:       op = 8'h04;
        3:       op = 8'h05;
        4:       op = 8'h01;
        5:       op = 8'h03;
        6, 7:    op = 8'h02;
        8:       op = 8'h13;
        9:       op = 8'h12;
        default: op = (n % 2 == 0) ? 8'hFF : 8'h16;
      endcase
      do_txn(op, 8'($urandom), int'($urandom_range(1, 4)), "R1");
      if (n % 6 == 5) do_txn(8'h05, 8'h00, 1, "R4");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule